// File: doc/BRIEF.md
# Configuration and Start-up Sequencer

This block steers a programmable device from power-up, or from an explicit program request, into user operation. It first clears the configuration memory and pulls the shared open-drain init line low while it does so. It then waits for that line to read high and captures the mode pins on that edge. Next it accepts configuration frames until the frame checker reports a CRC result. A matching CRC opens an eight-step start-up sequence. That sequence raises done, releases the global three-state net, releases the global set/reset net and enables global writes. A mismatch parks the block in an error state that only a new program request or a reset can clear.

Each of the four start-up events is placed on a chosen step from 1 to 6 of the sequence. Alternatively, the three global-net events can be made to wait for the external done line, so that devices in a chain leave start-up together. The memory-clear time is modelled by a counter of `CLR_CYCLES` clocks. Frame storage and CRC arithmetic sit outside the block.

Top module: `cfg_startup_seq`

## Requirements
- R1: Reset (`rst` high, the power-on condition) or `prog_n` sampled low on a rising edge restarts configuration, and `done_out` reads 0 after that edge.
- R2: `init_pull_low` is 1 throughout clearing. Clearing ends on the `CLR_CYCLES`-th rising edge after the last edge that saw `rst` high or `prog_n` low, so holding `prog_n` low extends it.
- R3: After the block releases init, it waits while `init_sense` reads 0. `mode_latched` loads `mode_pins` only on the edge where `init_sense` is first seen high, and keeps that value at all other times.
- R4: `crc_strobe` is acted on only while frames are being loaded. Strobes that arrive while waiting for init, during start-up, in user operation or in the error state change no output.
- R5: A strobe with `crc_match`=0 during loading sets `init_pull_low` to 1 on that edge and keeps it there with every start-up event withheld. Only `prog_n` low or `rst` recovers the block.
- R6: A strobe with `crc_match`=1 during loading starts the sequence. An event placed on step n takes effect on the (n+1)-th rising edge after the edge that accepted the strobe.
- R7: The step selections `sel_done`, `sel_tristate`, `sel_setreset` and `sel_wren` are captured only while `rst` is high. A selection of 0 acts as 1 and a selection of 7 acts as 6.
- R8: If `follow_done` bit 0 (three-state), bit 1 (set/reset) or bit 2 (write enable) is set, that event ignores its step. It takes effect on the first edge during start-up that samples `done_sense` high, which is one clock after the pin is seen high.
- R9: Until its event fires, each global output holds its safe value: `glb_tristate`=1, `glb_setreset`=1, `glb_wr_en`=0 and `done_out`=0. All four return to these values at reset and on a program request.
- R10: A program request and an accepted CRC match on the same edge resolve to the program request. Clearing restarts and no event fires.
- R11: Once start-up events have fired, their outputs stay put until the next program request or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset; also captures selections |
| prog_n | input | 1 | Active-low program request |
| init_sense | input | 1 | Level read back from the open-drain init line |
| mode_pins | input | MODE_W | Mode pin bus |
| crc_strobe | input | 1 | CRC result valid |
| crc_match | input | 1 | CRC result: 1 match, 0 mismatch |
| done_sense | input | 1 | Level read back from the external done line |
| sel_done | input | 3 | Step for asserting done |
| sel_tristate | input | 3 | Step for releasing global three-state |
| sel_setreset | input | 3 | Step for releasing global set/reset |
| sel_wren | input | 3 | Step for enabling global writes |
| follow_done | input | 3 | Per-event wait-for-done flags (bit 0 three-state, bit 1 set/reset, bit 2 write enable) |
| done_out | output | 1 | Done indication, 1 when start-up done event has fired |
| init_pull_low | output | 1 | 1 pulls the open-drain init line low |
| glb_tristate | output | 1 | Global three-state, 1 = outputs held in high impedance |
| glb_setreset | output | 1 | Global set/reset, 1 = flip-flops held |
| glb_wr_en | output | 1 | Global write enable, 1 = state may change |
| mode_latched | output | MODE_W | Mode pins captured on init release |

## Verification
A program request and a CRC match can be sampled on the same rising edge. The block has to settle that clash without letting any start-up event slip through. The bench brings the block into frame loading, asserts both on one edge, and then watches for the next ten clocks. It requires `init_pull_low` back at 1, `done_out` at 0 and every global net at its safe value. A second overlap comes from a follow-done event becoming due while a timed event lands on its own step. This is judged edge by edge against the step arithmetic with the done line looped back.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_RELEASE,
    ST_LOAD,
    ST_STARTUP,
    ST_RUN,
    ST_ERROR
  } seq_state_t;

  localparam int NUM_EV    = 4;
  localparam int STEP_W    = 3;
  localparam int LAST_STEP = (1 << STEP_W) - 1;

  localparam int EV_DONE = 0;
  localparam int EV_TRI  = 1;
  localparam int EV_SR   = 2;
  localparam int EV_WE   = 3;

  // Steps 0 and the last step are reserved; pull selections into 1..6.
  function automatic logic [STEP_W-1:0] clamp_sel(input logic [STEP_W-1:0] s);
    if (s == '0) return STEP_W'(1);
    if (s == STEP_W'(LAST_STEP)) return STEP_W'(LAST_STEP - 1);
    return s;
  endfunction

endpackage

// File: rtl/cfgseq_clear_timer.sv
module cfgseq_clear_timer #(
  parameter int CLR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CLR_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(CLR_CYCLES - 1));
endmodule

// File: rtl/cfgseq_event_slot.sv
module cfgseq_event_slot #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              active,
  input  logic [STEP_W-1:0] step,
  input  logic [STEP_W-1:0] sel,
  input  logic              follow,
  input  logic              done_sense,
  output logic              fired
);
  logic hit;

  assign hit = follow ? done_sense : (step == sel);

  always_ff @(posedge clk) begin
    if (rst || clear)       fired <= 1'b0;
    else if (active && hit) fired <= 1'b1;
  end
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfgseq_pkg::*;
#(
  parameter int CLR_CYCLES = 16,
  parameter int MODE_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_n,
  input  logic              init_sense,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              crc_strobe,
  input  logic              crc_match,
  input  logic              done_sense,
  input  logic [2:0]        sel_done,
  input  logic [2:0]        sel_tristate,
  input  logic [2:0]        sel_setreset,
  input  logic [2:0]        sel_wren,
  input  logic [2:0]        follow_done,
  output logic              done_out,
  output logic              init_pull_low,
  output logic              glb_tristate,
  output logic              glb_setreset,
  output logic              glb_wr_en,
  output logic [MODE_W-1:0] mode_latched
);

  seq_state_t              st, st_nxt;
  logic [STEP_W-1:0]       step;
  logic [STEP_W-1:0]       sel_q [NUM_EV];
  logic [NUM_EV-1:0]       follow_q;
  logic [NUM_EV-1:0]       fired;
  logic                    clr_expired;
  logic                    slot_active;

  // Selections are captured while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q[EV_DONE] <= clamp_sel(sel_done);
      sel_q[EV_TRI]  <= clamp_sel(sel_tristate);
      sel_q[EV_SR]   <= clamp_sel(sel_setreset);
      sel_q[EV_WE]   <= clamp_sel(sel_wren);
      follow_q       <= {follow_done, 1'b0};
    end
  end

  cfgseq_clear_timer #(.CLR_CYCLES(CLR_CYCLES)) i_clear_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (st == ST_CLEAR && prog_n),
    .expired (clr_expired)
  );

  always_comb begin
    st_nxt = st;
    if (!prog_n) begin
      st_nxt = ST_CLEAR;
    end else begin
      case (st)
        ST_CLEAR:   if (clr_expired) st_nxt = ST_RELEASE;
        ST_RELEASE: if (init_sense)  st_nxt = ST_LOAD;
        ST_LOAD:    if (crc_strobe)  st_nxt = crc_match ? ST_STARTUP : ST_ERROR;
        ST_STARTUP: if (step == STEP_W'(LAST_STEP) && &fired) st_nxt = ST_RUN;
        default:    st_nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_CLEAR;
      init_pull_low <= 1'b1;
      mode_latched  <= '0;
      step          <= '0;
    end else begin
      st            <= st_nxt;
      init_pull_low <= (st_nxt == ST_CLEAR) || (st_nxt == ST_ERROR);
      if (st == ST_RELEASE && st_nxt == ST_LOAD) mode_latched <= mode_pins;
      if (st != ST_STARTUP)                      step <= '0;
      else if (step != STEP_W'(LAST_STEP))       step <= step + 1'b1;
    end
  end

  assign slot_active = (st == ST_STARTUP) && prog_n;

  for (genvar e = 0; e < NUM_EV; e++) begin : g_slot
    cfgseq_event_slot #(.STEP_W(STEP_W)) i_slot (
      .clk        (clk),
      .rst        (rst),
      .clear      (!prog_n),
      .active     (slot_active),
      .step       (step),
      .sel        (sel_q[e]),
      .follow     (follow_q[e]),
      .done_sense (done_sense),
      .fired      (fired[e])
    );
  end

  assign done_out     =  fired[EV_DONE];
  assign glb_tristate = ~fired[EV_TRI];
  assign glb_setreset = ~fired[EV_SR];
  assign glb_wr_en    =  fired[EV_WE];

endmodule

// File: rtl/cfg_startup_checker.sv
module cfg_startup_checker #(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              prog_n,
  input logic              init_sense,
  input logic              done_out,
  input logic              init_pull_low,
  input logic              glb_tristate,
  input logic              glb_setreset,
  input logic              glb_wr_en,
  input logic [MODE_W-1:0] mode_latched
);

  AST_DONE_DROPS_ON_PROG: assert property (@(posedge clk) disable iff (rst)
    !prog_n |=> !done_out); // R1

  AST_INIT_PULLED_IN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !prog_n |=> init_pull_low); // R2

  AST_MODE_HELD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    !init_sense |=> $stable(mode_latched)); // R3

  AST_SAFE_WHILE_INIT_PULLED: assert property (@(posedge clk) disable iff (rst)
    init_pull_low |-> (glb_tristate && glb_setreset && !glb_wr_en && !done_out)); // R9

  AST_WREN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (prog_n && glb_wr_en) |=> glb_wr_en); // R11

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (prog_n && done_out) |=> done_out); // R11

endmodule

bind cfg_startup_seq cfg_startup_checker #(.MODE_W(MODE_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .prog_n        (prog_n),
  .init_sense    (init_sense),
  .done_out      (done_out),
  .init_pull_low (init_pull_low),
  .glb_tristate  (glb_tristate),
  .glb_setreset  (glb_setreset),
  .glb_wr_en     (glb_wr_en),
  .mode_latched  (mode_latched)
);

// File: tb/test_cfg_startup_seq.sv
`timescale 1ns/1ps
module test_cfg_startup_seq;

  localparam int CLR    = 16;
  localparam int MODE_W = 3;

  logic clk = 1'b0;
  logic rst, prog_n, crc_strobe, crc_match, ext_hold, ext_done, done_loop;
  logic [MODE_W-1:0] mode_pins;
  logic [2:0] sel_done, sel_tristate, sel_setreset, sel_wren, follow_done;
  logic init_sense, done_sense;
  logic done_out, init_pull_low, glb_tristate, glb_setreset, glb_wr_en;
  logic [MODE_W-1:0] mode_latched;
  logic [3:0] ev;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign init_sense = ~init_pull_low & ~ext_hold;
  assign done_sense = done_loop ? done_out : ext_done;
  assign ev = {done_out, glb_tristate, glb_setreset, glb_wr_en};

  cfg_startup_seq #(.CLR_CYCLES(CLR), .MODE_W(MODE_W)) i_cfg_startup_seq (
    .clk(clk), .rst(rst), .prog_n(prog_n), .init_sense(init_sense),
    .mode_pins(mode_pins), .crc_strobe(crc_strobe), .crc_match(crc_match),
    .done_sense(done_sense), .sel_done(sel_done), .sel_tristate(sel_tristate),
    .sel_setreset(sel_setreset), .sel_wren(sel_wren), .follow_done(follow_done),
    .done_out(done_out), .init_pull_low(init_pull_low), .glb_tristate(glb_tristate),
    .glb_setreset(glb_setreset), .glb_wr_en(glb_wr_en), .mode_latched(mode_latched)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input logic [2:0] d, t, s, w, f);
    sel_done = d; sel_tristate = t; sel_setreset = s; sel_wren = w; follow_done = f;
  endtask

  task automatic do_reset();
    rst = 1'b1; prog_n = 1'b1; crc_strobe = 1'b0; crc_match = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic go_to_load();
    for (int i = 0; i < 200 && init_pull_low; i++) tick();
    tick();
  endtask

  task automatic pulse_crc(input logic m);
    crc_strobe = 1'b1; crc_match = m;
    tick();
    crc_strobe = 1'b0;
  endtask

  task automatic t_reset_and_clear();
    configure(3'd2, 3'd3, 3'd4, 3'd5, 3'b000);
    do_reset();
    chk("R9 safe at reset", ev, 4'b0110);
    chk("R1 done low at reset", done_out, 0);
    chk("R3 mode cleared", mode_latched, 0);
    repeat (CLR - 1) tick();
    chk("R2 still clearing", init_pull_low, 1);
    tick();
    chk("R2 clear length", init_pull_low, 0);
    prog_n = 1'b0;
    repeat (5) tick();
    chk("R2 prog holds clear", init_pull_low, 1);
    prog_n = 1'b1;
    repeat (CLR - 1) tick();
    chk("R2 extended clear", init_pull_low, 1);
    tick();
    chk("R2 extended clear end", init_pull_low, 0);
  endtask

  task automatic t_init_hold_and_timing();
    configure(3'd2, 3'd3, 3'd4, 3'd5, 3'b000);
    ext_hold = 1'b1; mode_pins = 3'd5;
    do_reset();
    repeat (CLR + 2) tick();
    chk("R3 released by block", init_pull_low, 0);
    pulse_crc(1'b1);
    repeat (10) tick();
    chk("R4 strobe ignored while init held", ev, 4'b0110);
    chk("R3 mode not sampled while low", mode_latched, 0);
    mode_pins = 3'd6; ext_hold = 1'b0;
    tick();
    chk("R3 mode sampled on rise", mode_latched, 6);
    mode_pins = 3'd1;
    tick();
    chk("R3 mode held later", mode_latched, 6);
    pulse_crc(1'b1);
    for (int t = 1; t <= 8; t++) begin
      tick();
      chk("R6 timed events", ev, {t >= 3, !(t >= 4), !(t >= 5), t >= 6});
    end
    repeat (20) tick();
    chk("R11 events persist", ev, 4'b1001);
    pulse_crc(1'b0);
    tick();
    chk("R4 strobe ignored in run", {init_pull_low, ev}, 5'b01001);
    prog_n = 1'b0;
    tick();
    chk("R1 prog drops done", done_out, 0);
    chk("R9 safe after prog", ev, 4'b0110);
    prog_n = 1'b1;
  endtask

  task automatic t_crc_error();
    configure(3'd2, 3'd3, 3'd4, 3'd5, 3'b000);
    do_reset();
    go_to_load();
    pulse_crc(1'b0);
    chk("R5 init pulled on mismatch", init_pull_low, 1);
    repeat (30) tick();
    chk("R5 error persists", {init_pull_low, ev}, 5'b10110);
    pulse_crc(1'b1);
    repeat (10) tick();
    chk("R5 match ignored in error", {init_pull_low, ev}, 5'b10110);
    prog_n = 1'b0;
    tick();
    prog_n = 1'b1;
    go_to_load();
    pulse_crc(1'b1);
    repeat (8) tick();
    chk("R5 recovery by program", ev, 4'b1001);
  endtask

  task automatic t_clamp_and_latch();
    configure(3'd0, 3'd7, 3'd7, 3'd0, 3'b000);
    do_reset();
    configure(3'd5, 3'd5, 3'd5, 3'd5, 3'b111);
    go_to_load();
    pulse_crc(1'b1);
    for (int t = 1; t <= 8; t++) begin
      tick();
      chk("R7 clamped and latched", ev, {t >= 2, !(t >= 7), !(t >= 7), t >= 2});
    end
  endtask

  task automatic t_sync_external();
    configure(3'd2, 3'd1, 3'd1, 3'd1, 3'b111);
    ext_done = 1'b0; done_loop = 1'b0;
    do_reset();
    go_to_load();
    pulse_crc(1'b1);
    repeat (12) tick();
    chk("R8 waits for done pin", ev, 4'b1110);
    ext_done = 1'b1;
    chk("R8 not before edge", ev, 4'b1110);
    tick();
    chk("R8 follows done pin", ev, 4'b1001);
    ext_done = 1'b0;
  endtask

  task automatic t_sync_looped();
    configure(3'd3, 3'd2, 3'd2, 3'd1, 3'b100);
    done_loop = 1'b1;
    do_reset();
    go_to_load();
    pulse_crc(1'b1);
    for (int t = 1; t <= 6; t++) begin
      tick();
      chk("R8 write enable one clock after done", ev, {t >= 4, !(t >= 3), !(t >= 3), t >= 5});
    end
    done_loop = 1'b0;
  endtask

  task automatic t_prog_vs_crc();
    configure(3'd1, 3'd1, 3'd1, 3'd1, 3'b000);
    do_reset();
    go_to_load();
    crc_strobe = 1'b1; crc_match = 1'b1; prog_n = 1'b0;
    tick();
    crc_strobe = 1'b0; prog_n = 1'b1;
    chk("R10 program wins, clearing", init_pull_low, 1);
    repeat (10) tick();
    chk("R10 no event fired", {init_pull_low, ev}, 5'b10110);
  endtask

  initial begin
    rst = 1'b1; prog_n = 1'b1; crc_strobe = 1'b0; crc_match = 1'b0;
    ext_hold = 1'b0; ext_done = 1'b0; done_loop = 1'b0; mode_pins = '0;
    configure(3'd2, 3'd3, 3'd4, 3'd5, 3'b000);
    t_reset_and_clear();
    t_init_hold_and_timing();
    t_crc_error();
    t_clamp_and_latch();
    t_sync_external();
    t_sync_looped();
    t_prog_vs_crc();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule